// File: doc/BRIEF.md
# Grid Chain Growth Allocator

This block keeps a small two-dimensional grid of storage cells. Each data field is a chain of neighbouring cells that holds one bit per cell. Every cell holds a data bit, a link direction, a successor flag and an occupancy flag. A per-field reference table keeps the tail and head coordinates of each chain. A field can therefore grow one cell at a time, in any of four directions, without a fixed address range.

A create command starts a chain of length one at a given coordinate. An append command adds one bit next to the current head, in a chosen direction, and links the old head to the new cell. An append into an occupied cell or off the edge of the grid is blocked. A blocked create is also refused. Either case raises a crash report that names the field, and the report is held until it is acknowledged. While a report is pending, nothing in the grid or the table changes and all commands are refused. A registered read port returns any cell so that chains can be walked from outside.

Top module: `gc_chain_alloc`

## Requirements
- R1: Reset (synchronous, active high) leaves busy and crash_valid low and clears every cell, so that any cell reads back as 5'b00000.
- R2: rd_cell shows the cell at (rd_x, rd_y) one clock edge after those inputs are sampled. Bit 4 is occupied, bit 3 is successor present, bits 2:1 are the direction and bit 0 is the data bit.
- R3: A create (cmd_op=0) into a free cell writes occupied=1, successor=0, direction=00 and data=cmd_bit at (cmd_x, cmd_y). It sets that field's tail and head to this coordinate, and busy falls at the second edge after acceptance.
- R4: A successful append (cmd_op=1) writes a new head cell {1,0,00,cmd_bit} next to the old head. The direction codes are 00 up (y-1), 01 right (x+1), 10 down (y+1) and 11 left (x-1). The old head gets direction=cmd_dir and successor=1, the table head moves to the new cell, and busy falls at the third edge after acceptance.
- R5: A create or append whose target cell is already occupied raises crash_valid and writes no cell and no table entry.
- R6: An append that would leave the grid (x or y below 0 or above its last index) raises crash_valid and writes nothing.
- R7: A crash report carries the field number. After a blocked append it carries the table's tail and head. After a blocked create it carries the requested start coordinate in both.
- R8: crash_valid and its report stay unchanged until crash_ack is sampled high. No cell or table entry changes while the report is pending, and crash_valid is low after the edge that samples crash_ack.
- R9: A command is taken only at an edge where cmd_valid is high and busy is low. busy is high from the edge after acceptance until the command completes, and stays high while a crash is pending. Commands presented while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 create, 1 append |
| cmd_field | input | FW | Field number |
| cmd_x | input | XW | Start column for create |
| cmd_y | input | YW | Start row for create |
| cmd_dir | input | 2 | Append direction |
| cmd_bit | input | 1 | Data bit to store |
| busy | output | 1 | Command in progress or crash pending |
| crash_valid | output | 1 | Crash report held |
| crash_field | output | FW | Field that crashed |
| crash_tail_x | output | XW | Reported tail column |
| crash_tail_y | output | YW | Reported tail row |
| crash_head_x | output | XW | Reported head column |
| crash_head_y | output | YW | Reported head row |
| crash_ack | input | 1 | Clears the crash report |
| rd_x | input | XW | Read column |
| rd_y | input | YW | Read row |
| rd_cell | output | 5 | Registered cell contents |

## Verification
Clearing a crash and taking a new command can meet in the same cycle. The bench provokes this by raising crash_ack and cmd_valid together on one edge while a report is pending. The acknowledge must win: the report clears, the command is dropped because busy was still high, and the target cell still reads empty afterwards. A command presented during a held crash is judged the same way, and a later identical command must then succeed.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef struct packed {
    logic       occ;
    logic       conn;
    logic [1:0] dir;
    logic       data;
  } cell_t;

  localparam logic [1:0] DIR_UP    = 2'b00;
  localparam logic [1:0] DIR_RIGHT = 2'b01;
  localparam logic [1:0] DIR_DOWN  = 2'b10;
  localparam logic [1:0] DIR_LEFT  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LINK  = 2'd2
  } state_t;
endpackage

// File: rtl/gc_cell_mem.sv
module gc_cell_mem #(
  parameter int W  = 8,
  parameter int H  = 8,
  parameter int XW = $clog2(W),
  parameter int YW = $clog2(H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [XW-1:0]     wx,
  input  logic [YW-1:0]     wy,
  input  gc_pkg::cell_t     wdata,
  input  logic [XW-1:0]     ax,
  input  logic [YW-1:0]     ay,
  output gc_pkg::cell_t     adata,
  input  logic [XW-1:0]     rx,
  input  logic [YW-1:0]     ry,
  output gc_pkg::cell_t     rdata
);
  localparam int DEPTH = W * H;
  localparam int AW    = $clog2(DEPTH);

  gc_pkg::cell_t mem [DEPTH];

  function automatic logic [AW-1:0] idx(input logic [XW-1:0] x, input logic [YW-1:0] y);
    return AW'(y) * AW'(W) + AW'(x);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx(wx, wy)] <= wdata;
    end
  end

  assign adata = mem[idx(ax, ay)];

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[idx(rx, ry)];
  end
endmodule

// File: rtl/gc_ref_table.sv
module gc_ref_table #(
  parameter int FIELDS = 4,
  parameter int FW     = $clog2(FIELDS),
  parameter int XW     = 3,
  parameter int YW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [FW-1:0] wf,
  input  logic [XW-1:0] w_tx,
  input  logic [YW-1:0] w_ty,
  input  logic [XW-1:0] w_hx,
  input  logic [YW-1:0] w_hy,
  input  logic [FW-1:0] rf,
  output logic [XW-1:0] r_tx,
  output logic [YW-1:0] r_ty,
  output logic [XW-1:0] r_hx,
  output logic [YW-1:0] r_hy
);
  logic [XW-1:0] tx_m [FIELDS];
  logic [YW-1:0] ty_m [FIELDS];
  logic [XW-1:0] hx_m [FIELDS];
  logic [YW-1:0] hy_m [FIELDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FIELDS; i++) begin
        tx_m[i] <= '0; ty_m[i] <= '0; hx_m[i] <= '0; hy_m[i] <= '0;
      end
    end else if (we) begin
      tx_m[wf] <= w_tx; ty_m[wf] <= w_ty;
      hx_m[wf] <= w_hx; hy_m[wf] <= w_hy;
    end
  end

  assign r_tx = tx_m[rf];
  assign r_ty = ty_m[rf];
  assign r_hx = hx_m[rf];
  assign r_hy = hy_m[rf];
endmodule

// File: rtl/gc_step.sv
module gc_step #(
  parameter int W  = 8,
  parameter int H  = 8,
  parameter int XW = $clog2(W),
  parameter int YW = $clog2(H)
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [1:0]    dir,
  output logic [XW-1:0] nx,
  output logic [YW-1:0] ny,
  output logic          wall
);
  always_comb begin
    nx   = x;
    ny   = y;
    wall = 1'b0;
    case (dir)
      gc_pkg::DIR_UP:    if (y == '0) wall = 1'b1; else ny = y - 1'b1;
      gc_pkg::DIR_RIGHT: if (x == XW'(W - 1)) wall = 1'b1; else nx = x + 1'b1;
      gc_pkg::DIR_DOWN:  if (y == YW'(H - 1)) wall = 1'b1; else ny = y + 1'b1;
      default:           if (x == '0) wall = 1'b1; else nx = x - 1'b1;
    endcase
  end
endmodule

// File: rtl/gc_chain_alloc.sv
module gc_chain_alloc #(
  parameter int GRID_W = 8,
  parameter int GRID_H = 8,
  parameter int FIELDS = 4,
  parameter int XW     = $clog2(GRID_W),
  parameter int YW     = $clog2(GRID_H),
  parameter int FW     = $clog2(FIELDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [FW-1:0] cmd_field,
  input  logic [XW-1:0] cmd_x,
  input  logic [YW-1:0] cmd_y,
  input  logic [1:0]    cmd_dir,
  input  logic          cmd_bit,
  output logic          busy,
  output logic          crash_valid,
  output logic [FW-1:0] crash_field,
  output logic [XW-1:0] crash_tail_x,
  output logic [YW-1:0] crash_tail_y,
  output logic [XW-1:0] crash_head_x,
  output logic [YW-1:0] crash_head_y,
  input  logic          crash_ack,
  input  logic [XW-1:0] rd_x,
  input  logic [YW-1:0] rd_y,
  output logic [4:0]    rd_cell
);
  import gc_pkg::*;

  state_t        state;
  logic          op_q, bit_q;
  logic [FW-1:0] fld_q;
  logic [XW-1:0] sx_q, hx_q, nx_q;
  logic [YW-1:0] sy_q, hy_q, ny_q;
  logic [1:0]    dir_q;

  logic [XW-1:0] t_tx, t_hx, st_nx, ax;
  logic [YW-1:0] t_ty, t_hy, st_ny, ay;
  logic          st_wall, fail;
  cell_t         probe, rd_q;

  logic          cell_we, tbl_we;
  logic [XW-1:0] cell_wx, tbl_tx, tbl_hx;
  logic [YW-1:0] cell_wy, tbl_ty, tbl_hy;
  cell_t         cell_wd;

  gc_ref_table #(.FIELDS(FIELDS), .FW(FW), .XW(XW), .YW(YW)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .wf(fld_q),
    .w_tx(tbl_tx), .w_ty(tbl_ty), .w_hx(tbl_hx), .w_hy(tbl_hy),
    .rf(fld_q), .r_tx(t_tx), .r_ty(t_ty), .r_hx(t_hx), .r_hy(t_hy)
  );

  gc_step #(.W(GRID_W), .H(GRID_H), .XW(XW), .YW(YW)) u_step (
    .x(t_hx), .y(t_hy), .dir(dir_q), .nx(st_nx), .ny(st_ny), .wall(st_wall)
  );

  gc_cell_mem #(.W(GRID_W), .H(GRID_H), .XW(XW), .YW(YW)) u_mem (
    .clk(clk), .rst(rst), .we(cell_we), .wx(cell_wx), .wy(cell_wy), .wdata(cell_wd),
    .ax(ax), .ay(ay), .adata(probe), .rx(rd_x), .ry(rd_y), .rdata(rd_q)
  );

  assign rd_cell = rd_q;

  // probe address: start cell for create, step target for append, old head when linking
  always_comb begin
    if (state == ST_LINK) begin
      ax = hx_q; ay = hy_q;
    end else if (!op_q) begin
      ax = sx_q; ay = sy_q;
    end else begin
      ax = st_nx; ay = st_ny;
    end
  end

  assign fail = op_q ? (st_wall || probe.occ) : probe.occ;

  always_comb begin
    cell_we = 1'b0; cell_wx = ax; cell_wy = ay;
    cell_wd = '{occ: 1'b1, conn: 1'b0, dir: DIR_UP, data: bit_q};
    tbl_we  = 1'b0;
    tbl_tx  = t_tx; tbl_ty = t_ty; tbl_hx = t_hx; tbl_hy = t_hy;
    case (state)
      ST_CHECK: begin
        if (!fail) begin
          cell_we = 1'b1;
          if (!op_q) begin
            tbl_we = 1'b1;
            tbl_tx = sx_q; tbl_ty = sy_q; tbl_hx = sx_q; tbl_hy = sy_q;
          end
        end
      end
      ST_LINK: begin
        cell_we = 1'b1;
        cell_wd = '{occ: 1'b1, conn: 1'b1, dir: dir_q, data: probe.data};
        tbl_we  = 1'b1;
        tbl_hx  = nx_q; tbl_hy = ny_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; busy <= 1'b0; crash_valid <= 1'b0;
      crash_field <= '0; crash_tail_x <= '0; crash_tail_y <= '0;
      crash_head_x <= '0; crash_head_y <= '0;
      op_q <= 1'b0; bit_q <= 1'b0; fld_q <= '0; dir_q <= '0;
      sx_q <= '0; sy_q <= '0; hx_q <= '0; hy_q <= '0; nx_q <= '0; ny_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (crash_valid) begin
            if (crash_ack) begin
              crash_valid <= 1'b0;
              busy        <= 1'b0;
            end
          end else if (cmd_valid && !busy) begin
            op_q <= cmd_op; fld_q <= cmd_field; sx_q <= cmd_x; sy_q <= cmd_y;
            dir_q <= cmd_dir; bit_q <= cmd_bit;
            busy  <= 1'b1;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fail) begin
            crash_valid <= 1'b1;
            crash_field <= fld_q;
            crash_tail_x <= op_q ? t_tx : sx_q;
            crash_tail_y <= op_q ? t_ty : sy_q;
            crash_head_x <= op_q ? t_hx : sx_q;
            crash_head_y <= op_q ? t_hy : sy_q;
            state <= ST_IDLE;
          end else if (!op_q) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            hx_q <= t_hx; hy_q <= t_hy; nx_q <= st_nx; ny_q <= st_ny;
            state <= ST_LINK;
          end
        end
        default: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/gc_chain_chk.sv
module gc_chain_chk #(
  parameter int FW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          crash_valid,
  input logic          crash_ack,
  input logic [FW-1:0] crash_field,
  input logic          cell_we,
  input logic          tbl_we
);
  // R9
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  // R9
  crash_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
    crash_valid |-> busy);

  // R8
  crash_held_chk: assert property (@(posedge clk) disable iff (rst)
    (crash_valid && !crash_ack) |=> (crash_valid && $stable(crash_field)));

  // R8
  crash_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    crash_valid |-> (!cell_we && !tbl_we));

  // R8
  crash_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (crash_valid && crash_ack) |=> !crash_valid);
endmodule

bind gc_chain_alloc gc_chain_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .crash_valid(crash_valid), .crash_ack(crash_ack), .crash_field(crash_field),
  .cell_we(cell_we), .tbl_we(tbl_we)
);

// File: tb/test_gc_chain_alloc.sv
module test_gc_chain_alloc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_bit = 1'b0, crash_ack = 1'b0;
  logic [1:0] cmd_field = '0, cmd_dir = '0, crash_field;
  logic [2:0] cmd_x = '0, cmd_y = '0, rd_x = '0, rd_y = '0;
  logic [2:0] crash_tail_x, crash_tail_y, crash_head_x, crash_head_y;
  logic busy, crash_valid;
  logic [4:0] rd_cell;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gc_chain_alloc i_gc_chain_alloc (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_field(cmd_field),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_dir(cmd_dir), .cmd_bit(cmd_bit),
    .busy(busy), .crash_valid(crash_valid), .crash_field(crash_field),
    .crash_tail_x(crash_tail_x), .crash_tail_y(crash_tail_y),
    .crash_head_x(crash_head_x), .crash_head_y(crash_head_y),
    .crash_ack(crash_ack), .rd_x(rd_x), .rd_y(rd_y), .rd_cell(rd_cell)
  );

  // {op, field, x, y, dir, bit, crash, tail_x, tail_y, head_x, head_y}
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 2'd0, 3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd0, 3'd0, 3'd0, 2'd1, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd0, 3'd0, 3'd0, 2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 3'd1, 3'd1},
    {1'b0, 2'd1, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1, 3'd1, 3'd1, 3'd1, 3'd1},
    {1'b0, 2'd1, 3'd7, 3'd7, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd1, 3'd0, 3'd0, 2'd1, 1'b0, 1'b1, 3'd7, 3'd7, 3'd7, 3'd7},
    {1'b1, 2'd1, 3'd0, 3'd0, 2'd2, 1'b0, 1'b1, 3'd7, 3'd7, 3'd7, 3'd7},
    {1'b1, 2'd1, 3'd0, 3'd0, 2'd3, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd1, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd0, 3'd0, 3'd0, 2'd3, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 2'd0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic issue(input logic op, input logic [1:0] f, input logic [2:0] x,
                       input logic [2:0] y, input logic [1:0] d, input logic b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_field = f; cmd_x = x; cmd_y = y;
    cmd_dir = d; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 busy after accept", 32'(busy), 32'd1);
    for (int i = 0; i < 10; i++) begin
      if (!busy || crash_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic read_cell(input logic [2:0] x, input logic [2:0] y, output logic [4:0] c);
    @(negedge clk);
    rd_x = x; rd_y = y;
    @(negedge clk);
    c = rd_cell;
  endtask

  task automatic ack();
    @(negedge clk);
    crash_ack = 1'b1;
    @(negedge clk);
    crash_ack = 1'b0;
    chk("R8 crash cleared by ack", 32'(crash_valid), 32'd0);
    chk("R8 busy low after ack", 32'(busy), 32'd0);
  endtask

  initial begin
    logic [4:0] c;
    logic [24:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy at reset", 32'(busy), 32'd0);
    chk("R1 crash at reset", 32'(crash_valid), 32'd0);
    read_cell(3'd0, 3'd0, c);
    chk("R1 cell empty at reset", 32'(c), 32'd0);

    for (int k = 0; k < 12; k++) begin
      v = VEC[k];
      issue(v[24], v[23:22], v[21:19], v[18:16], v[15:14], v[13]);
      chk($sformatf("R5 R6 crash flag vector %0d", k), 32'(crash_valid), 32'(v[12]));
      if (v[12]) begin
        chk($sformatf("R7 field vector %0d", k), 32'(crash_field), 32'(v[23:22]));
        chk($sformatf("R7 tail vector %0d", k), {26'd0, crash_tail_x, crash_tail_y}, 32'(v[11:6]));
        chk($sformatf("R7 head vector %0d", k), {26'd0, crash_head_x, crash_head_y}, 32'(v[5:0]));
        ack();
      end else begin
        chk($sformatf("R3 R4 done vector %0d", k), 32'(busy), 32'd0);
      end
    end

    // R2 R3 R4 cell layout {occ, conn, dir[1:0], data}
    read_cell(3'd0, 3'd0, c); chk("R4 tail linked right", 32'(c), 32'b11011);
    read_cell(3'd1, 3'd0, c); chk("R4 link down", 32'(c), 32'b11100);
    read_cell(3'd1, 3'd1, c); chk("R4 link left after crash", 32'(c), 32'b11111);
    read_cell(3'd0, 3'd1, c); chk("R5 head untouched by crash", 32'(c), 32'b10000);
    read_cell(3'd7, 3'd7, c); chk("R6 wall crash left start intact then linked", 32'(c), 32'b11110);
    read_cell(3'd6, 3'd7, c); chk("R4 link up", 32'(c), 32'b11001);
    read_cell(3'd6, 3'd6, c); chk("R2 new head format", 32'(c), 32'b10000);
    read_cell(3'd5, 3'd5, c); chk("R2 unused cell empty", 32'(c), 32'b00000);

    // R8 crash held, commands refused
    issue(1'b1, 2'd0, 3'd0, 3'd0, 2'd0, 1'b1);
    chk("R5 crash on occupied", 32'(crash_valid), 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 crash held", 32'(crash_valid), 32'd1);
    chk("R8 field held", 32'(crash_field), 32'd0);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_field = 2'd2; cmd_x = 3'd3; cmd_y = 3'd3; cmd_bit = 1'b1;
    @(negedge clk);
    cmd_x = 3'd4; cmd_y = 3'd4; crash_ack = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; crash_ack = 1'b0;
    chk("R8 ack wins over command", 32'(crash_valid), 32'd0);
    chk("R9 command with ack dropped", 32'(busy), 32'd0);
    read_cell(3'd3, 3'd3, c); chk("R9 refused while crash pending", 32'(c), 32'd0);
    read_cell(3'd4, 3'd4, c); chk("R9 refused on ack edge", 32'(c), 32'd0);
    read_cell(3'd0, 3'd1, c); chk("R8 head unchanged during crash", 32'(c), 32'b10000);

    issue(1'b0, 2'd2, 3'd3, 3'd3, 2'd0, 1'b1);
    chk("R3 create after ack", 32'(crash_valid), 32'd0);
    read_cell(3'd3, 3'd3, c); chk("R3 created cell", 32'(c), 32'b10001);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 busy after reset", 32'(busy), 32'd0);
    read_cell(3'd0, 3'd0, c); chk("R1 cells cleared", 32'(c), 32'd0);
    finish_run();
  end
endmodule